// File: doc/BRIEF.md
# Host Bridge Configuration Register File

This block is the register side of a PCI host bridge, as seen by a processor over a simple 32-bit register bus. It keeps a local 256-byte configuration header for the bridge itself, a configuration address register and two base registers whose writes are masked. It also has a data port. Reading or writing the data port starts one indirect configuration transaction on a request/acknowledge side channel, aimed at the address held in the address register. The bus is stalled until that transaction is acknowledged.

Two small pieces of combinational routing sit beside the registers. A fixed 256 KiB processor I/O window is remapped into downstream I/O space using the upper bits of the I/O base register. Downstream interrupt lines, one per slot, are folded onto four interrupt outputs by slot number.

The bus contract is simple. The processor raises `bus_sel` with a stable address, write flag and data, and holds them until it samples `bus_ready` high at a rising clock edge. Every access is a full word, and address bits 1:0 are ignored.

Top module: `hb_cfg_regfile`

## Requirements
- R1: Word offsets 0x000 to 0x0FC read and write the 64-word local header. A whole 32-bit word is stored, with bits 7:0 at the lowest byte offset. Address bits 1:0 are ignored. Such an access completes in the cycle it is presented, with `bus_ready` high.
- R2: After reset, header word 0x004 reads 0x02900080 and every other header word reads zero. This value is the command word 0x0080 (wait-cycle bit 7) plus the status word 0x0290 (bits 4, 7 and 9).
- R3: Offset 0x1C0, the configuration address register, keeps all 32 written bits and reads them back unchanged. It resets to zero.
- R4: Offset 0x1C4, the memory base register, keeps only the bits under mask 0xFF000001. All other bits read zero. It resets to zero.
- R5: Offset 0x1C8, the I/O base register, keeps only the bits under mask 0xFFFC0001. It resets to zero.
- R6: A write to offset 0x220 raises `cfg_req` with `cfg_we`=1, `cfg_addr` equal to the address register and `cfg_wdata` equal to the written data. These stay stable until `cfg_ack`. `bus_ready` stays low until the cycle after the acknowledge. Exactly one request is issued per access.
- R7: A read of offset 0x220 raises `cfg_req` with `cfg_we`=0. It completes with `bus_rdata` equal to the `cfg_rdata` presented alongside `cfg_ack`, with the same stall as R6.
- R8: Every other offset in the address space reads zero and completes at once. A write to such an offset changes no register.
- R9: A processor address in [0xFE240000, 0xFE280000) sets `io_hit`. In that case `io_addr_out` = (I/O base & 0xFFFC0000) + (address − 0xFE240000). Outside the window, `io_hit` is 0 and `io_addr_out` is 0.
- R10: `irq_out[k]` is the OR of every `dev_irq[s]` with s mod 4 = k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access request, held until ready |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access completes at this edge |
| cfg_req | output | 1 | Indirect configuration request pending |
| cfg_we | output | 1 | 1 = configuration write |
| cfg_addr | output | 32 | Configuration address |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_ack | input | 1 | Request completed (one cycle) |
| cfg_rdata | input | 32 | Read data valid with cfg_ack |
| cpu_io_addr | input | 32 | Processor address checked against the I/O window |
| io_hit | output | 1 | Address is inside the window |
| io_addr_out | output | 32 | Translated downstream I/O address |
| dev_irq | input | 8 | Interrupt line per downstream slot |
| irq_out | output | 4 | Routed interrupt outputs |

## Verification
The header is swept word by word with a pattern derived from each index. This separates index decoding errors from data path errors. Misaligned addresses are then tried, to show that bits 1:0 are dropped.

The base registers take all-ones, alternating and walking patterns, which expose any wrong bit in a mask. Every unmapped word offset is written and read, and the held registers are re-read afterwards to catch stray decoding.

The data port is run with acknowledge delays of one to four cycles and with distinct addresses and data. The stall length and the single request then show whether the handshake is counted correctly. The I/O window is probed at both edges and just outside them under several base values. The interrupt router is tried with all 256 line patterns.

// File: rtl/hbc_pkg.sv
// Package hbc_pkg: shared offsets, masks, reset constants and the data-port
// state type for the host bridge configuration register file.
package hbc_pkg;
    localparam int unsigned OFS_ADDR_REG = 32'h1C0;
    localparam int unsigned OFS_MEM_BASE = 32'h1C4;
    localparam int unsigned OFS_IO_BASE  = 32'h1C8;
    localparam int unsigned OFS_DATA     = 32'h220;
    localparam int unsigned HDR_BYTES    = 256;

    localparam logic [31:0] MEM_BASE_MASK = 32'hFF00_0001;
    localparam logic [31:0] IO_BASE_MASK  = 32'hFFFC_0001;

    // Header word 1: status (cap list, fast b2b, medium devsel) : command (wait)
    localparam logic [15:0] RST_COMMAND = 16'h0080;
    localparam logic [15:0] RST_STATUS  = 16'h0290;

    typedef enum logic [1:0] {
        PORT_IDLE = 2'd0,
        PORT_WAIT = 2'd1,
        PORT_DONE = 2'd2
    } port_state_t;
endpackage

// File: rtl/hbc_hdr_store.sv
// Module hbc_hdr_store: word-wide storage for the bridge's local
// configuration header. One write port, one combinational read port.
// Assumes: whole-word accesses only; the word index is already decoded.
module hbc_hdr_store #(
    parameter int WORDS = 64,
    parameter int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [31:0]      rdata
);
    import hbc_pkg::*;

    logic [31:0] mem [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        localparam logic [31:0] RST_VAL =
            (w == 1) ? {RST_STATUS, RST_COMMAND} : 32'h0;
        // Hold one header word; load its fixed value on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[w] <= RST_VAL;
            else if (we && (widx == IDX_W'(w)))
                mem[w] <= wdata;
        end
    end

    // Return the selected word.
    always_comb rdata = mem[ridx];
endmodule

// File: rtl/hbc_cfg_port.sv
// Module hbc_cfg_port: turns a data-port access into one request/acknowledge
// configuration transaction and stalls the register bus until it completes.
// Assumes: the initiator holds its access stable until it sees ready; the
// responder pulses ack for one cycle per request.
module hbc_cfg_port (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        start_we,
    input  logic [31:0] start_wdata,
    input  logic [31:0] held_addr,
    output logic        idle,
    output logic        done,
    output logic [31:0] done_rdata,
    output logic        cfg_req,
    output logic        cfg_we,
    output logic [31:0] cfg_addr,
    output logic [31:0] cfg_wdata,
    input  logic        cfg_ack,
    input  logic [31:0] cfg_rdata
);
    import hbc_pkg::*;

    port_state_t state, state_nx;
    logic        we_q;
    logic [31:0] wdata_q;
    logic [31:0] rdata_q;

    // Next-state choice for the one-outstanding transaction sequencer.
    always_comb begin
        state_nx = state;
        unique case (state)
            PORT_IDLE: if (start)   state_nx = PORT_WAIT;
            PORT_WAIT: if (cfg_ack) state_nx = PORT_DONE;
            PORT_DONE:              state_nx = PORT_IDLE;
            default:                state_nx = PORT_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PORT_IDLE;
        else        state <= state_nx;
    end

    // Capture direction and write data when a transaction opens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else if (state == PORT_IDLE && start) begin
            we_q    <= start_we;
            wdata_q <= start_wdata;
        end
    end

    // Capture response data at the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (state == PORT_WAIT && cfg_ack)
            rdata_q <= cfg_rdata;
    end

    // Drive the side channel and the completion flags.
    always_comb begin
        idle       = (state == PORT_IDLE);
        done       = (state == PORT_DONE);
        done_rdata = rdata_q;
        cfg_req    = (state == PORT_WAIT);
        cfg_we     = we_q;
        cfg_addr   = held_addr;
        cfg_wdata  = wdata_q;
    end
endmodule

// File: rtl/hbc_io_window.sv
// Module hbc_io_window: detects processor addresses inside a fixed
// power-of-two I/O window and rebases them onto the programmed I/O base.
// Assumes: WIN_BASE is aligned to 2**WIN_BITS.
module hbc_io_window #(
    parameter logic [31:0] WIN_BASE = 32'hFE24_0000,
    parameter int          WIN_BITS = 18
) (
    input  logic [31:0] cpu_addr,
    input  logic [31:0] io_base,
    output logic        hit,
    output logic [31:0] out_addr
);
    // Compare the upper bits and splice the base above the window offset.
    always_comb begin
        hit      = (cpu_addr[31:WIN_BITS] == WIN_BASE[31:WIN_BITS]);
        out_addr = hit ? {io_base[31:WIN_BITS], cpu_addr[WIN_BITS-1:0]} : 32'h0;
    end
endmodule

// File: rtl/hbc_irq_route.sv
// Module hbc_irq_route: folds per-slot interrupt lines onto OUTS outputs,
// each slot going to output (slot mod OUTS).
// Assumes: lines are level interrupts already synchronous to the system.
module hbc_irq_route #(
    parameter int SLOTS = 8,
    parameter int OUTS  = 4
) (
    input  logic [SLOTS-1:0] dev_irq,
    output logic [OUTS-1:0]  irq_out
);
    for (genvar k = 0; k < OUTS; k++) begin : g_out
        // OR together every slot that lands on output k.
        always_comb begin
            irq_out[k] = 1'b0;
            for (int s = k; s < SLOTS; s += OUTS)
                irq_out[k] = irq_out[k] | dev_irq[s];
        end
    end
endmodule

// File: rtl/hb_cfg_regfile.sv
// Module hb_cfg_regfile: register file of a PCI host bridge on a 32-bit
// register bus. It decodes header, address, base and data-port offsets,
// sequences indirect configuration accesses and hosts the I/O window and
// interrupt routing.
// Assumes: word accesses; the initiator holds an access until bus_ready.
module hb_cfg_regfile #(
    parameter int          ADDR_W    = 10,
    parameter int          SLOTS     = 8,
    parameter int          IRQ_OUTS  = 4,
    parameter logic [31:0] IO_WIN    = 32'hFE24_0000,
    parameter int          IO_WIN_W  = 18
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                bus_ready,
    output logic                cfg_req,
    output logic                cfg_we,
    output logic [31:0]         cfg_addr,
    output logic [31:0]         cfg_wdata,
    input  logic                cfg_ack,
    input  logic [31:0]         cfg_rdata,
    input  logic [31:0]         cpu_io_addr,
    output logic                io_hit,
    output logic [31:0]         io_addr_out,
    input  logic [SLOTS-1:0]    dev_irq,
    output logic [IRQ_OUTS-1:0] irq_out
);
    import hbc_pkg::*;

    localparam int HDR_WORDS = HDR_BYTES / 4;
    localparam int HDR_IDX_W = $clog2(HDR_WORDS);

    logic [ADDR_W-1:0]    word_addr;
    logic                 sel_hdr, sel_areg, sel_mbase, sel_iobase, sel_data;
    logic                 port_idle, port_done;
    logic [31:0]          port_rdata;
    logic [31:0]          hdr_rdata;
    logic [31:0]          addr_reg, mem_base, io_base;
    logic                 do_write;
    logic [HDR_IDX_W-1:0] hdr_idx;

    // Decode the word-aligned offset into register selects.
    always_comb begin
        word_addr  = {bus_addr[ADDR_W-1:2], 2'b00};
        sel_hdr    = (int'(word_addr) < HDR_BYTES);
        sel_areg   = (word_addr == ADDR_W'(OFS_ADDR_REG));
        sel_mbase  = (word_addr == ADDR_W'(OFS_MEM_BASE));
        sel_iobase = (word_addr == ADDR_W'(OFS_IO_BASE));
        sel_data   = (word_addr == ADDR_W'(OFS_DATA));
        hdr_idx    = word_addr[HDR_IDX_W+1:2];
        do_write   = bus_sel && bus_wr && port_idle && !sel_data;
    end

    hbc_hdr_store #(.WORDS(HDR_WORDS), .IDX_W(HDR_IDX_W)) u_hdr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (do_write && sel_hdr),
        .widx  (hdr_idx),
        .wdata (bus_wdata),
        .ridx  (hdr_idx),
        .rdata (hdr_rdata)
    );

    // Hold the address and base registers, masking the base writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_reg <= '0;
            mem_base <= '0;
            io_base  <= '0;
        end else if (do_write) begin
            if (sel_areg)   addr_reg <= bus_wdata;
            if (sel_mbase)  mem_base <= bus_wdata & MEM_BASE_MASK;
            if (sel_iobase) io_base  <= bus_wdata & IO_BASE_MASK;
        end
    end

    hbc_cfg_port u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (bus_sel && sel_data),
        .start_we    (bus_wr),
        .start_wdata (bus_wdata),
        .held_addr   (addr_reg),
        .idle        (port_idle),
        .done        (port_done),
        .done_rdata  (port_rdata),
        .cfg_req     (cfg_req),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .cfg_ack     (cfg_ack),
        .cfg_rdata   (cfg_rdata)
    );

    // Select read data and signal completion on the register bus.
    always_comb begin
        if (sel_data) begin
            bus_ready = bus_sel && port_done;
            bus_rdata = port_done ? port_rdata : 32'h0;
        end else begin
            bus_ready = bus_sel && port_idle;
            if (sel_hdr)         bus_rdata = hdr_rdata;
            else if (sel_areg)   bus_rdata = addr_reg;
            else if (sel_mbase)  bus_rdata = mem_base;
            else if (sel_iobase) bus_rdata = io_base;
            else                 bus_rdata = 32'h0;
        end
    end

    hbc_io_window #(.WIN_BASE(IO_WIN), .WIN_BITS(IO_WIN_W)) u_iowin (
        .cpu_addr (cpu_io_addr),
        .io_base  (io_base),
        .hit      (io_hit),
        .out_addr (io_addr_out)
    );

    hbc_irq_route #(.SLOTS(SLOTS), .OUTS(IRQ_OUTS)) u_irq (
        .dev_irq (dev_irq),
        .irq_out (irq_out)
    );
endmodule

// File: rtl/hbc_chk.sv
// Module hbc_chk: port-level properties of hb_cfg_regfile, bound to it below.
module hbc_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              bus_ready,
    input logic              cfg_req,
    input logic              cfg_we,
    input logic [31:0]       cfg_addr,
    input logic [31:0]       cfg_wdata,
    input logic              cfg_ack,
    input logic [31:0]       cpu_io_addr,
    input logic              io_hit,
    input logic [31:0]       io_addr_out
);
    logic [ADDR_W-1:0] wa;
    logic is_data, is_mbase, is_iobase, is_unmapped;

    always_comb begin
        wa          = {bus_addr[ADDR_W-1:2], 2'b00};
        is_data     = (wa == ADDR_W'(32'h220));
        is_mbase    = (wa == ADDR_W'(32'h1C4));
        is_iobase   = (wa == ADDR_W'(32'h1C8));
        is_unmapped = (int'(wa) >= 256) && !is_data && !is_mbase && !is_iobase
                      && (wa != ADDR_W'(32'h1C0));
    end

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && !cfg_ack |=> cfg_req);
    // R6
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && !cfg_ack |=> $stable(cfg_addr) && $stable(cfg_we) && $stable(cfg_wdata));
    // R7
    port_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && is_data && bus_ready |-> $past(cfg_ack) && !cfg_req);
    // R4
    mbase_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !bus_wr && is_mbase |-> (bus_rdata & ~32'hFF00_0001) == 32'h0);
    // R5
    iobase_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !bus_wr && is_iobase |-> (bus_rdata & ~32'hFFFC_0001) == 32'h0);
    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !bus_wr && is_unmapped |-> bus_ready && bus_rdata == 32'h0);
    // R9
    io_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_hit |-> io_addr_out == 32'h0);
    // R9
    io_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_hit |-> io_addr_out[17:0] == cpu_io_addr[17:0]);
    // R2
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !cfg_req);
endmodule

bind hb_cfg_regfile hbc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .bus_ready   (bus_ready),
    .cfg_req     (cfg_req),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .cfg_ack     (cfg_ack),
    .cpu_io_addr (cpu_io_addr),
    .io_hit      (io_hit),
    .io_addr_out (io_addr_out)
);

// File: tb/tb_hb_cfg_regfile.sv
module tb_hb_cfg_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        cfg_req, cfg_we;
    logic [31:0] cfg_addr, cfg_wdata;
    logic        cfg_ack = 1'b0;
    logic [31:0] cfg_rdata = '0;
    logic [31:0] cpu_io_addr = '0;
    logic        io_hit;
    logic [31:0] io_addr_out;
    logic [7:0]  dev_irq = '0;
    logic [3:0]  irq_out;

    int n_checks = 0, n_fail = 0;
    int ack_delay = 1, ack_cnt = 0, req_count = 0;
    logic        seen_we;
    logic [31:0] seen_addr, seen_wdata;
    bit          finished = 0;

    always #5 clk = ~clk;

    hb_cfg_regfile dut (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] resp_data(input logic [31:0] a);
        return (a ^ 32'hC33C_5AA5) + 32'd17;
    endfunction

    // Configuration responder: acknowledges each request after ack_delay cycles.
    always @(negedge clk) begin
        if (cfg_ack) begin
            cfg_ack <= 1'b0;
        end else if (cfg_req) begin
            if (ack_cnt + 1 >= ack_delay) begin
                cfg_ack    <= 1'b1;
                cfg_rdata  <= resp_data(cfg_addr);
                seen_we    = cfg_we;
                seen_addr  = cfg_addr;
                seen_wdata = cfg_wdata;
                req_count++;
                ack_cnt = 0;
            end else begin
                ack_cnt++;
            end
        end
    end

    // One bus access; returns read data and the number of stalled samples.
    task automatic xfer(input bit wr, input logic [9:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int stalls);
        stalls = 0;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        forever begin
            #1;
            if (bus_ready) break;
            stalls++;
            @(negedge clk);
        end
        rd = bus_rdata;
        @(posedge clk);
        #1 bus_sel = 1'b0;
    endtask

    task automatic wr32(input logic [9:0] a, input logic [31:0] d);
        logic [31:0] x; int s;
        xfer(1'b1, a, d, x, s);
    endtask

    task automatic rd32(input logic [9:0] a, output logic [31:0] r);
        int s;
        xfer(1'b0, a, 32'h0, r, s);
    endtask

    function automatic logic [31:0] hdr_pat(input int i);
        return (32'(i) * 32'h0101_0101) ^ 32'hA50F_3C96;
    endfunction

    initial begin
        logic [31:0] r, r2;
        int st, rc0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset contents of the header and held registers
        for (int i = 0; i < 64; i++) begin
            rd32(10'(i * 4), r);
            check(r == ((i == 1) ? 32'h0290_0080 : 32'h0), "R2 header reset", r,
                  (i == 1) ? 32'h0290_0080 : 32'h0);
        end
        rd32(10'h1C0, r); check(r == 0, "R3 reset", r, 0);
        rd32(10'h1C4, r); check(r == 0, "R4 reset", r, 0);
        rd32(10'h1C8, r); check(r == 0, "R5 reset", r, 0);

        // R1: full header sweep, then misaligned offsets
        for (int i = 0; i < 64; i++) wr32(10'(i * 4), hdr_pat(i));
        for (int i = 0; i < 64; i++) begin
            rd32(10'(i * 4), r);
            check(r == hdr_pat(i), "R1 header word", r, hdr_pat(i));
        end
        wr32(10'h013, 32'hDEAD_BEEF);
        rd32(10'h010, r);
        check(r == 32'hDEAD_BEEF, "R1 low bits ignored", r, 32'hDEAD_BEEF);
        rd32(10'h0FE, r);
        check(r == hdr_pat(63), "R1 top word misaligned", r, hdr_pat(63));

        // R3/R4/R5: masked registers with several patterns
        for (int p = 0; p < 36; p++) begin
            logic [31:0] v;
            v = (p < 32) ? (32'h1 << p) : ((p == 32) ? 32'hFFFF_FFFF :
                (p == 33) ? 32'hAAAA_AAAA : (p == 34) ? 32'h5555_5555 : 32'h1234_5679);
            wr32(10'h1C0, v); rd32(10'h1C0, r); check(r == v, "R3 address reg", r, v);
            wr32(10'h1C4, v); rd32(10'h1C4, r);
            check(r == (v & 32'hFF00_0001), "R4 memory base mask", r, v & 32'hFF00_0001);
            wr32(10'h1C8, v); rd32(10'h1C8, r);
            check(r == (v & 32'hFFFC_0001), "R5 io base mask", r, v & 32'hFFFC_0001);
        end

        // R8: every unmapped word reads zero and writes change nothing
        wr32(10'h1C0, 32'h0BAD_F00D); wr32(10'h1C4, 32'hFFFF_FFFF); wr32(10'h1C8, 32'hFFFF_FFFF);
        rc0 = req_count;
        for (int a = 256; a < 1024; a += 4) begin
            if (a == 'h1C0 || a == 'h1C4 || a == 'h1C8 || a == 'h220) continue;
            wr32(10'(a), 32'hFFFF_FFFF);
            rd32(10'(a), r);
            check(r == 0, "R8 unmapped read", r, 0);
        end
        rd32(10'h1C0, r); check(r == 32'h0BAD_F00D, "R8 address reg untouched", r, 32'h0BAD_F00D);
        rd32(10'h1C4, r); check(r == 32'hFF00_0001, "R8 memory base untouched", r, 32'hFF00_0001);
        rd32(10'h1C8, r); check(r == 32'hFFFC_0001, "R8 io base untouched", r, 32'hFFFC_0001);
        rd32(10'h000, r); check(r == hdr_pat(0), "R8 header untouched", r, hdr_pat(0));
        check(req_count == rc0, "R8 no config request", 32'(req_count), 32'(rc0));

        // R6/R7: data port with delays 1..4
        for (int d = 1; d <= 4; d++) begin
            logic [31:0] ca, wd;
            ca = 32'h8000_0000 | (32'(d) << 11) | 32'h10;
            wd = 32'h7700_0000 + 32'(d * 3);
            ack_delay = d;
            wr32(10'h1C0, ca);
            rc0 = req_count;
            xfer(1'b1, 10'h220, wd, r, st);
            check(st == d + 1, "R6 write stall cycles", 32'(st), 32'(d + 1));
            check(req_count == rc0 + 1, "R6 one request", 32'(req_count), 32'(rc0 + 1));
            check(seen_we == 1'b1, "R6 write flag", 32'(seen_we), 1);
            check(seen_addr == ca, "R6 address", seen_addr, ca);
            check(seen_wdata == wd, "R6 write data", seen_wdata, wd);
            xfer(1'b0, 10'h223, 32'h0, r, st);
            check(st == d + 1, "R7 read stall cycles", 32'(st), 32'(d + 1));
            check(seen_we == 1'b0, "R7 read flag", 32'(seen_we), 0);
            check(r == resp_data(ca), "R7 read data", r, resp_data(ca));
            check(req_count == rc0 + 2, "R7 one request", 32'(req_count), 32'(rc0 + 2));
            rd32(10'h1C4, r2);
            check(r2 == 32'hFF00_0001, "R1 plain access after port", r2, 32'hFF00_0001);
        end

        // R9: I/O window edges under several base values
        for (int b = 0; b < 4; b++) begin
            logic [31:0] base, probes[6];
            base = (b == 0) ? 32'h0 : (b == 1) ? 32'hFFFF_FFFF : (b == 2) ? 32'h0004_0000 : 32'h1234_5678;
            wr32(10'h1C8, base);
            probes = '{32'hFE23_FFFF, 32'hFE24_0000, 32'hFE25_2345,
                       32'hFE27_FFFF, 32'hFE28_0000, 32'h0000_1000};
            foreach (probes[k]) begin
                bit          ein;
                logic [31:0] eo;
                @(negedge clk);
                cpu_io_addr = probes[k];
                #1;
                ein = (probes[k] >= 32'hFE24_0000) && (probes[k] < 32'hFE28_0000);
                eo  = ein ? (base & 32'hFFFC_0000) + (probes[k] - 32'hFE24_0000) : 32'h0;
                check(io_hit == ein, "R9 window hit", 32'(io_hit), 32'(ein));
                check(io_addr_out == eo, "R9 translated address", io_addr_out, eo);
            end
        end

        // R10: all interrupt patterns
        for (int p = 0; p < 256; p++) begin
            logic [3:0] e;
            @(negedge clk);
            dev_irq = 8'(p);
            #1;
            for (int k = 0; k < 4; k++) e[k] = p[k] | p[k + 4];
            check(irq_out == e, "R10 interrupt routing", 32'(irq_out), 32'(e));
        end

        finished = 1;
    end

    initial begin
        int cyc = 0;
        while (!finished && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%08h expected=%08h", cyc, 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule